// File: doc/BRIEF.md
# Cyclic Mapping and Communication State Controller

This block sits in a drive-side slave of a framed serial protocol and owns the switch between two communication states. In the configuration state every frame carries six words: a header, four configuration words and a check word. In the cyclic state the frame also carries a cyclic data field whose length follows from a set of mapping tables. Upstream logic decodes register writes from configuration frames and hands each one to this block as an address and a 32-bit value. The block answers every write it owns with an acknowledge or a 32-bit error code.

Two tables describe the cyclic field, one for each direction: master-to-slave (Rx) and slave-to-master (Tx). Each table has up to fifteen entries. Each entry names a dictionary register and its size in bytes. Each table also has an entry count. Every new entry is checked against the wider dictionary through a lookup port. When the master asks for the cyclic state, the tables are checked for gaps and for the word budget.

A state change is acknowledged in the frame format that is current when the request arrives. The state and the frame size change only when the transport logic strobes that the reply has been sent. Downstream framing logic reads back any stored entry by direction and index, and reads the per-direction cyclic word counts and the total frame length.

Top module: `cyc_map_ctrl`

## Requirements
- R1: After reset the block is in the configuration state: `cyclic_mode`=0, `rx_words`=`tx_words`=0, `frame_words`=6, `resp_valid`=0.
- R2: A write to 0x651..0x65F (Rx index 1..15) or 0x661..0x66F (Tx index 1..15) that passes its checks is acknowledged one cycle later with `resp_valid`=1, `resp_err`=0 and `resp_code`=0. The data word is split as bits 31:16 = size in bytes and bits 15:0 = register address. It is stored, and the lookup port returns it for that direction (`map_dir` 0 = Rx, 1 = Tx) and index.
- R3: An entry whose register address is above 0x7FF, or for which the dictionary reports no such register (`dict_hit`=0), is refused with code 0x06020000 and is not stored.
- R4: An entry whose size differs from `dict_bytes`, or is zero, odd, or larger than the whole cyclic field (64 bytes), is refused with code 0x06040041 and is not stored.
- R5: A count write (0x650 for Rx, 0x660 for Tx) with a value up to 15 is acknowledged and stored. A larger value is refused with code 0x06040041.
- R6: Writing 2 to the state register 0x640 while some entry with index 1..count is empty in either table is refused with code 0x08010000, and the block stays in the configuration state.
- R7: Writing 2 to 0x640 when a direction's mapped bytes, halved, exceed 32 words is refused with code 0x06040042, and the block stays in the configuration state.
- R8: An accepted request for the cyclic state is acknowledged, but the state does not change until `reply_sent` is strobed. On the cycle after that strobe, `cyclic_mode`=1 and each direction's word count equals the sum of its first count entry sizes divided by 2. `frame_words` then equals 6 plus the larger of the two counts.
- R9: While in the cyclic state, or while a state change waits for `reply_sent`, writes to count or entry registers are refused with code 0x06010000 and change nothing. A further state write in the waiting window is refused with the same code.
- R10: Writing 1 to 0x640 in the cyclic state is acknowledged while the cyclic state is kept. The cycle after `reply_sent`, the block is in the configuration state, both word counts are 0 and `frame_words`=6.
- R11: Writing any value other than 1 or 2 to 0x640 is refused with code 0x08000000. Writes to any address outside 0x640, 0x650..0x65F and 0x660..0x66F get no response.
- R12: A `reply_sent` strobe with no state change waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| wr_valid | input | 1 | Decoded register write present this cycle |
| wr_addr | input | 12 | Register address of the write |
| wr_data | input | 32 | Value of the write |
| reply_sent | input | 1 | Strobe: the reply to the last accepted write has left the slave |
| dict_addr | output | 11 | Register address to look up in the dictionary (from `wr_data`) |
| dict_hit | input | 1 | Dictionary holds `dict_addr` |
| dict_bytes | input | 16 | Size in bytes of `dict_addr` |
| map_dir | input | 1 | Lookup direction: 0 = Rx, 1 = Tx |
| map_idx | input | 4 | Lookup entry index, 1..15 |
| map_addr | output | 16 | Register address of the looked-up entry, 0 when empty |
| map_bytes | output | 16 | Size in bytes of the looked-up entry, 0 when empty |
| cyclic_mode | output | 1 | 1 in the cyclic state |
| rx_words | output | 6 | Words of Rx cyclic data, 0 in the configuration state |
| tx_words | output | 6 | Words of Tx cyclic data, 0 in the configuration state |
| frame_words | output | 6 | Frame length in words |
| resp_valid | output | 1 | Response to a write is present |
| resp_err | output | 1 | Response is an error |
| resp_code | output | 32 | Error code, 0 on acknowledge |

## Verification
Each write response is registered, so it is due exactly one cycle after the write cycle. The bench drives a write at a falling edge and samples the response at the next falling edge. The state, the word counts and the frame length change one cycle after the `reply_sent` strobe. They are sampled before the strobe, to confirm that nothing has moved yet, and one falling edge after it. The entry lookup is combinational on the stored table, so it is sampled a short delay after `map_dir` and `map_idx` are driven, in a cycle with no write.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    // Register map of the communication-state block
    localparam logic [11:0] ADDR_STATE   = 12'h640;
    localparam logic [11:0] ADDR_RX_BASE = 12'h650;
    localparam logic [11:0] ADDR_TX_BASE = 12'h660;

    // Values accepted by the state register
    localparam logic [31:0] STATE_VAL_CONFIG = 32'd1;
    localparam logic [31:0] STATE_VAL_CYCLIC = 32'd2;

    // Error codes returned on refused writes
    localparam logic [31:0] ERR_UNSUPPORTED = 32'h0601_0000;
    localparam logic [31:0] ERR_NO_REGISTER = 32'h0602_0000;
    localparam logic [31:0] ERR_NOT_MAPPABLE = 32'h0604_0041;
    localparam logic [31:0] ERR_OVER_BUDGET = 32'h0604_0042;
    localparam logic [31:0] ERR_GENERAL     = 32'h0800_0000;
    localparam logic [31:0] ERR_INDEX_GAP   = 32'h0801_0000;

    localparam logic [15:0] DICT_MAX_ADDR = 16'h07FF;

    typedef enum logic {
        ST_CONFIG = 1'b0,
        ST_CYCLIC = 1'b1
    } comm_state_e;

    typedef struct packed {
        logic [15:0] size;
        logic [15:0] addr;
    } map_entry_t;

endpackage

// File: rtl/cmc_map_table.sv
module cmc_map_table
    import cmc_pkg::*;
#(
    parameter int N_ENT = 15,
    parameter int IDX_W = $clog2(N_ENT + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  map_entry_t                   wr_entry,
    input  logic [IDX_W-1:0]             rd_idx,
    output map_entry_t                   rd_entry,
    output logic [N_ENT-1:0]             vld_o,
    output map_entry_t [N_ENT-1:0]       ent_o
);

    typedef struct packed {
        map_entry_t [N_ENT-1:0] ent;
        logic [N_ENT-1:0]       vld;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    function automatic logic idx_in_range(input logic [IDX_W-1:0] idx);
        return (idx != '0) && (int'(idx) <= N_ENT);
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && idx_in_range(wr_idx)) begin
            tbl_d.ent[wr_idx - IDX_W'(1)] = wr_entry;
            tbl_d.vld[wr_idx - IDX_W'(1)] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rd_entry = '0;
        if (idx_in_range(rd_idx) && tbl_q.vld[rd_idx - IDX_W'(1)]) begin
            rd_entry = tbl_q.ent[rd_idx - IDX_W'(1)];
        end
    end

    assign vld_o = tbl_q.vld;
    assign ent_o = tbl_q.ent;

    // R4: the controller only ever stores sizes that are even and nonzero
    p_even_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_entry.size[0] == 1'b0 && wr_entry.size != 16'd0));

endmodule

// File: rtl/cmc_validator.sv
module cmc_validator
    import cmc_pkg::*;
#(
    parameter int N_ENT     = 15,
    parameter int MAX_WORDS = 32,
    parameter int IDX_W     = $clog2(N_ENT + 1),
    parameter int SUM_W     = $clog2(N_ENT * 2 * MAX_WORDS + 1)
) (
    input  logic [N_ENT-1:0]       vld,
    input  map_entry_t [N_ENT-1:0] ent,
    input  logic [IDX_W-1:0]       count,
    output logic                   gap,
    output logic                   over,
    output logic [SUM_W-1:0]       words
);

    logic [SUM_W-1:0] bytes_sum;

    always_comb begin
        gap       = 1'b0;
        bytes_sum = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (i < int'(count)) begin
                if (!vld[i]) begin
                    gap = 1'b1;
                end
                bytes_sum = bytes_sum + SUM_W'(ent[i].size);
            end
        end
        words = bytes_sum >> 1;
        over  = int'(words) > MAX_WORDS;
    end

endmodule

// File: rtl/cyc_map_ctrl.sv
module cyc_map_ctrl
    import cmc_pkg::*;
#(
    parameter int N_ENT           = 15,
    parameter int MAX_WORDS       = 32,
    parameter int CFG_FRAME_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic        reply_sent,
    output logic [10:0] dict_addr,
    input  logic        dict_hit,
    input  logic [15:0] dict_bytes,
    input  logic        map_dir,
    input  logic [3:0]  map_idx,
    output logic [15:0] map_addr,
    output logic [15:0] map_bytes,
    output logic        cyclic_mode,
    output logic [5:0]  rx_words,
    output logic [5:0]  tx_words,
    output logic [5:0]  frame_words,
    output logic        resp_valid,
    output logic        resp_err,
    output logic [31:0] resp_code
);

    localparam int N_DIR     = 2;
    localparam int IDX_W     = $clog2(N_ENT + 1);
    localparam int SUM_W     = $clog2(N_ENT * 2 * MAX_WORDS + 1);
    localparam int CW_W      = $clog2(MAX_WORDS + 1);
    localparam int FW_W      = $clog2(CFG_FRAME_WORDS + MAX_WORDS + 1);
    localparam int MAX_BYTES = 2 * MAX_WORDS;

    typedef struct packed {
        comm_state_e                state;
        logic                       pend;
        comm_state_e                pend_tgt;
        logic [N_DIR-1:0][CW_W-1:0] words;
        logic [N_DIR-1:0][CW_W-1:0] pwords;
        logic [N_DIR-1:0][IDX_W-1:0] cnt;
        logic                       resp_valid;
        logic                       resp_err;
        logic [31:0]                resp_code;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_DIR-1:0]              tbl_we;
    map_entry_t                    new_entry;
    map_entry_t [N_DIR-1:0]        rd_entry;
    logic [N_DIR-1:0]              v_gap;
    logic [N_DIR-1:0]              v_over;
    logic [N_DIR-1:0][SUM_W-1:0]   v_words;
    logic [IDX_W-1:0]              wr_idx;
    logic [IDX_W-1:0]              rd_idx;

    assign new_entry = map_entry_t'(wr_data);
    assign wr_idx    = IDX_W'(wr_addr[3:0]);
    assign rd_idx    = IDX_W'(map_idx);
    assign dict_addr = wr_data[10:0];

    // One table and one checker per direction (0 = Rx, 1 = Tx)
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        logic [N_ENT-1:0]       vld;
        map_entry_t [N_ENT-1:0] ent;

        cmc_map_table #(
            .N_ENT (N_ENT),
            .IDX_W (IDX_W)
        ) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (tbl_we[g]),
            .wr_idx   (wr_idx),
            .wr_entry (new_entry),
            .rd_idx   (rd_idx),
            .rd_entry (rd_entry[g]),
            .vld_o    (vld),
            .ent_o    (ent)
        );

        cmc_validator #(
            .N_ENT     (N_ENT),
            .MAX_WORDS (MAX_WORDS),
            .IDX_W     (IDX_W),
            .SUM_W     (SUM_W)
        ) u_check (
            .vld   (vld),
            .ent   (ent),
            .count (ctl_q.cnt[g]),
            .gap   (v_gap[g]),
            .over  (v_over[g]),
            .words (v_words[g])
        );
    end

    // Address decode
    logic        hit_state;
    logic [N_DIR-1:0] hit_blk;
    logic        idx_zero;
    logic        idx_ok;

    always_comb begin
        hit_state  = (wr_addr == ADDR_STATE);
        hit_blk[0] = (wr_addr[11:4] == ADDR_RX_BASE[11:4]);
        hit_blk[1] = (wr_addr[11:4] == ADDR_TX_BASE[11:4]);
        idx_zero   = (wr_addr[3:0] == 4'd0);
        idx_ok     = !idx_zero && (int'(wr_addr[3:0]) <= N_ENT);
    end

    function automatic logic size_bad(input logic [15:0] sz, input logic [15:0] dsz);
        return (sz != dsz) || (sz == 16'd0) || sz[0] || (int'(sz) > MAX_BYTES);
    endfunction

    always_comb begin
        logic locked;
        int   dsel;

        ctl_d            = ctl_q;
        ctl_d.resp_valid = 1'b0;
        ctl_d.resp_err   = 1'b0;
        ctl_d.resp_code  = '0;
        tbl_we           = '0;
        locked           = (ctl_q.state == ST_CYCLIC) || ctl_q.pend;
        dsel             = hit_blk[1] ? 1 : 0;

        // Deferred state switch once the reply has left
        if (ctl_q.pend && reply_sent) begin
            ctl_d.pend  = 1'b0;
            ctl_d.state = ctl_q.pend_tgt;
            ctl_d.words = (ctl_q.pend_tgt == ST_CYCLIC) ? ctl_q.pwords : '0;
        end

        if (wr_valid) begin
            if (hit_state) begin
                ctl_d.resp_valid = 1'b1;
                if (ctl_q.pend) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_UNSUPPORTED;
                end else if (wr_data == STATE_VAL_CONFIG) begin
                    if (ctl_q.state == ST_CYCLIC) begin
                        ctl_d.pend     = 1'b1;
                        ctl_d.pend_tgt = ST_CONFIG;
                    end
                end else if (wr_data == STATE_VAL_CYCLIC) begin
                    if (ctl_q.state == ST_CONFIG) begin
                        if (|v_gap) begin
                            ctl_d.resp_err  = 1'b1;
                            ctl_d.resp_code = ERR_INDEX_GAP;
                        end else if (|v_over) begin
                            ctl_d.resp_err  = 1'b1;
                            ctl_d.resp_code = ERR_OVER_BUDGET;
                        end else begin
                            ctl_d.pend     = 1'b1;
                            ctl_d.pend_tgt = ST_CYCLIC;
                            for (int d = 0; d < N_DIR; d++) begin
                                ctl_d.pwords[d] = CW_W'(v_words[d]);
                            end
                        end
                    end
                end else begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_GENERAL;
                end
            end else if ((|hit_blk) && idx_zero) begin
                ctl_d.resp_valid = 1'b1;
                if (locked) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_UNSUPPORTED;
                end else if (wr_data > 32'(N_ENT)) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_NOT_MAPPABLE;
                end else begin
                    ctl_d.cnt[dsel] = IDX_W'(wr_data);
                end
            end else if ((|hit_blk) && idx_ok) begin
                ctl_d.resp_valid = 1'b1;
                if (locked) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_UNSUPPORTED;
                end else if (new_entry.addr > DICT_MAX_ADDR || !dict_hit) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_NO_REGISTER;
                end else if (size_bad(new_entry.size, dict_bytes)) begin
                    ctl_d.resp_err  = 1'b1;
                    ctl_d.resp_code = ERR_NOT_MAPPABLE;
                end else begin
                    tbl_we[dsel] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Outputs
    logic [CW_W-1:0] wmax;
    assign wmax        = (ctl_q.words[0] >= ctl_q.words[1]) ? ctl_q.words[0] : ctl_q.words[1];
    assign cyclic_mode = (ctl_q.state == ST_CYCLIC);
    assign rx_words    = 6'(ctl_q.words[0]);
    assign tx_words    = 6'(ctl_q.words[1]);
    assign frame_words = 6'(FW_W'(CFG_FRAME_WORDS) + (cyclic_mode ? FW_W'(wmax) : FW_W'(0)));
    assign map_addr    = rd_entry[map_dir].addr;
    assign map_bytes   = rd_entry[map_dir].size;
    assign resp_valid  = ctl_q.resp_valid;
    assign resp_err    = ctl_q.resp_err;
    assign resp_code   = ctl_q.resp_code;

    // R2: a response only ever follows a write by one cycle
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(wr_valid));

    // R8: the state only moves on the cycle after a reply strobe
    p_switch_on_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cyclic_mode) |-> $past(reply_sent));

    // R10: no cyclic words are reported in the configuration state
    p_config_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cyclic_mode |-> (rx_words == '0 && tx_words == '0));

    // R7: the word budget is never exceeded in either direction
    p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_words) <= MAX_WORDS) && (int'(tx_words) <= MAX_WORDS));

endmodule

// File: tb/cyc_map_ctrl_tb_top.sv
module cyc_map_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        reply_sent = 1'b0;
    logic [10:0] dict_addr;
    logic        dict_hit = 1'b0;
    logic [15:0] dict_bytes = '0;
    logic        map_dir = 1'b0;
    logic [3:0]  map_idx = '0;
    logic [15:0] map_addr;
    logic [15:0] map_bytes;
    logic        cyclic_mode;
    logic [5:0]  rx_words;
    logic [5:0]  tx_words;
    logic [5:0]  frame_words;
    logic        resp_valid;
    logic        resp_err;
    logic [31:0] resp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cyc_map_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .reply_sent  (reply_sent),
        .dict_addr   (dict_addr),
        .dict_hit    (dict_hit),
        .dict_bytes  (dict_bytes),
        .map_dir     (map_dir),
        .map_idx     (map_idx),
        .map_addr    (map_addr),
        .map_bytes   (map_bytes),
        .cyclic_mode (cyclic_mode),
        .rx_words    (rx_words),
        .tx_words    (tx_words),
        .frame_words (frame_words),
        .resp_valid  (resp_valid),
        .resp_err    (resp_err),
        .resp_code   (resp_code)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] data;
        logic        hit;
        logic [15:0] bytes;
        logic        err;
        logic [31:0] code;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{12'h651, 32'h0004_0038, 1'b1, 16'd4, 1'b0, 32'h0,          8'd2},  // R2 Rx 1
        '{12'h652, 32'h0002_0456, 1'b1, 16'd2, 1'b0, 32'h0,          8'd2},  // R2 Rx 2
        '{12'h661, 32'h0004_0205, 1'b1, 16'd4, 1'b0, 32'h0,          8'd2},  // R2 Tx 1
        '{12'h653, 32'h0004_0100, 1'b0, 16'd4, 1'b1, 32'h0602_0000,  8'd3},  // R3 absent
        '{12'h653, 32'h0004_0900, 1'b1, 16'd4, 1'b1, 32'h0602_0000,  8'd3},  // R3 above 0x7FF
        '{12'h653, 32'h0002_0100, 1'b1, 16'd4, 1'b1, 32'h0604_0041,  8'd4},  // R4 mismatch
        '{12'h653, 32'h0003_0100, 1'b1, 16'd3, 1'b1, 32'h0604_0041,  8'd4},  // R4 odd
        '{12'h653, 32'h0050_0100, 1'b1, 16'd80, 1'b1, 32'h0604_0041, 8'd4},  // R4 too large
        '{12'h650, 32'd16,        1'b0, 16'd0, 1'b1, 32'h0604_0041,  8'd5},  // R5 count high
        '{12'h650, 32'd3,         1'b0, 16'd0, 1'b0, 32'h0,          8'd5},  // R5 count ok
        '{12'h660, 32'd1,         1'b0, 16'd0, 1'b0, 32'h0,          8'd5},  // R5 Tx count
        '{12'h640, 32'd2,         1'b0, 16'd0, 1'b1, 32'h0801_0000,  8'd6},  // R6 gap at Rx 3
        '{12'h640, 32'd5,         1'b0, 16'd0, 1'b1, 32'h0800_0000,  8'd11}  // R11 bad value
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive a write at a falling edge; the response is due at the next one
    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input logic h, input logic [15:0] b);
        @(negedge clk);
        wr_valid   = 1'b1;
        wr_addr    = a;
        wr_data    = d;
        dict_hit   = h;
        dict_bytes = b;
        @(negedge clk);
        wr_valid   = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic err, input logic [31:0] code);
        chk(resp_valid === 1'b1, req, 32'(resp_valid), 32'd1);
        chk(resp_err === err && resp_code === code, req, resp_code, code);
    endtask

    task automatic pulse_reply();
        @(negedge clk);
        reply_sent = 1'b1;
        @(negedge clk);
        reply_sent = 1'b0;
    endtask

    task automatic look(input string req, input logic dir, input logic [3:0] idx,
                        input logic [15:0] ea, input logic [15:0] eb);
        map_dir = dir;
        map_idx = idx;
        #1;
        chk(map_addr === ea && map_bytes === eb, req, {map_bytes, map_addr}, {eb, ea});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cyclic_mode === 1'b0 && rx_words === 6'd0 && tx_words === 6'd0, "R1", 32'(cyclic_mode), 32'd0);
        chk(frame_words === 6'd6 && resp_valid === 1'b0, "R1", 32'(frame_words), 32'd6);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            do_write(VECS[i].addr, VECS[i].data, VECS[i].hit, VECS[i].bytes);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            expect_resp(tag, VECS[i].err, VECS[i].code);
        end

        // R6: refused request keeps configuration state
        chk(cyclic_mode === 1'b0 && frame_words === 6'd6, "R6", 32'(cyclic_mode), 32'd0);
        // R2: stored entries readable; R3/R4: refused entry left empty
        look("R2", 1'b0, 4'd1, 16'h0038, 16'd4);
        look("R2", 1'b1, 4'd1, 16'h0205, 16'd4);
        look("R3", 1'b0, 4'd3, 16'h0000, 16'd0);

        // R11: address outside the block gets no response
        do_write(12'h700, 32'd2, 1'b1, 16'd2);
        chk(resp_valid === 1'b0, "R11", 32'(resp_valid), 32'd0);

        // R12: stray reply strobe changes nothing
        pulse_reply();
        chk(cyclic_mode === 1'b0 && rx_words === 6'd0, "R12", 32'(cyclic_mode), 32'd0);

        // R7: Rx total 4+2+64 bytes = 35 words
        do_write(12'h653, 32'h0040_0100, 1'b1, 16'd64);
        expect_resp("R7 entry", 1'b0, 32'h0);
        do_write(12'h640, 32'd2, 1'b0, 16'd0);
        expect_resp("R7", 1'b1, 32'h0604_0042);
        chk(cyclic_mode === 1'b0, "R7", 32'(cyclic_mode), 32'd0);

        // R8: Rx 4+2+2 bytes = 4 words, Tx 4 bytes = 2 words
        do_write(12'h653, 32'h0002_0100, 1'b1, 16'd2);
        expect_resp("R8 entry", 1'b0, 32'h0);
        look("R8", 1'b0, 4'd3, 16'h0100, 16'd2);
        do_write(12'h640, 32'd2, 1'b0, 16'd0);
        expect_resp("R8", 1'b0, 32'h0);
        chk(cyclic_mode === 1'b0 && frame_words === 6'd6, "R8 before reply", 32'(cyclic_mode), 32'd0);

        // R9: writes in the waiting window are refused
        do_write(12'h652, 32'h0004_0456, 1'b1, 16'd4);
        expect_resp("R9 pending", 1'b1, 32'h0601_0000);
        do_write(12'h640, 32'd1, 1'b0, 16'd0);
        expect_resp("R9 pending state", 1'b1, 32'h0601_0000);
        chk(cyclic_mode === 1'b0, "R8 still waiting", 32'(cyclic_mode), 32'd0);

        pulse_reply();
        chk(cyclic_mode === 1'b1, "R8", 32'(cyclic_mode), 32'd1);
        chk(rx_words === 6'd4 && tx_words === 6'd2, "R8", {rx_words, tx_words}, {6'd4, 6'd2});
        chk(frame_words === 6'd10, "R8", 32'(frame_words), 32'd10);

        // R9: mapping locked in cyclic state
        do_write(12'h660, 32'd0, 1'b0, 16'd0);
        expect_resp("R9", 1'b1, 32'h0601_0000);
        look("R9", 1'b0, 4'd2, 16'h0456, 16'd2);

        // R10: leaving cyclic state
        do_write(12'h640, 32'd1, 1'b0, 16'd0);
        expect_resp("R10", 1'b0, 32'h0);
        chk(cyclic_mode === 1'b1 && frame_words === 6'd10, "R10 before reply", 32'(frame_words), 32'd10);
        pulse_reply();
        chk(cyclic_mode === 1'b0 && rx_words === 6'd0 && tx_words === 6'd0, "R10", 32'(cyclic_mode), 32'd0);
        chk(frame_words === 6'd6, "R10", 32'(frame_words), 32'd6);

        // R9: unlocked again in configuration state
        do_write(12'h660, 32'd0, 1'b0, 16'd0);
        expect_resp("R9 unlocked", 1'b0, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule